// File: doc/BRIEF.md
# Trigger Timestamp Capture Unit

This block maintains a free-running global time counter whose value always counts 10 ns units, whichever reference rate drives it. A tick-enable input marks each period of the external reference, and a two-bit rate select sets how many 10 ns units each tick adds. A shared start-of-run clear input sets the counter to zero. Separate acquisition systems that receive the same reference and the same clear therefore hold identical time values.

Every rising edge on the trigger input stamps the current counter value into a 64-entry queue. Stamping never waits on the host, so the block can serve as a dead-time-free monitor: a trigger is lost only when the queue is full, and a sticky flag records that loss. The host drains the queue through a valid/ready read stream that carries each stamp as two 32-bit words, the low word first.

The read stream obeys the usual valid/ready rules. A word transfers on a clock edge where `rd_valid` and `rd_ready` are both high. While `rd_valid` is high and `rd_ready` is low, the word and its half marker are held unchanged. Back-pressure from the host never stalls stamping. It only lets entries build up in the queue.

Top module: `tstamp_capture`

## Requirements
- R1: After reset, `time_now` is zero, `fifo_empty` is high, `fifo_count` is zero, `overflow` is low and `rd_valid` is low.
- R2: In a cycle where `ref_tick` is high and no clear acts, the counter adds a step set by `ref_sel`: 2'b00 adds 1, 2'b01 adds 4, 2'b10 adds 10 and 2'b11 adds 1. In every other cycle without a clear, the counter holds its value.
- R3: A rising edge on `clr_in` (low in one sampled cycle, high in the next) makes `time_now` read zero after the third rising clock edge that follows the input change. A level held high clears only once.
- R4: A rising edge on `trig_in` reaches the capture register after the same three-edge latency. The value pushed is the counter value held in the cycle before that capture edge. A level held high yields exactly one stamp.
- R5: When a clear edge and a trigger edge reach the capture register in the same cycle, the stamp recorded is zero and the counter restarts from zero.
- R6: The head stamp is presented first as bits [31:0] with `rd_hi` low, and then as {16'b0, bits [47:32]} with `rd_hi` high. An entry leaves the queue only after its high word is transferred. Stamps come out in the order they were captured.
- R7: While `rd_valid` is high and `rd_ready` is low, `rd_valid`, `rd_data` and `rd_hi` stay stable on the next cycle.
- R8: A capture and a pop in the same cycle both take effect, so host reads never delay or block stamping.
- R9: The queue holds 64 entries. A trigger edge that arrives while `fifo_count` is 64 is dropped and sets `overflow`. The flag stays set until a cycle with `ovf_clr` high that has no drop, and reading the queue does not clear it.
- R10: The counter wraps from all ones to zero (modulo 2^CNT_W), with no flag and no other effect.
- R11: `fifo_count` equals the number of stored stamps, and `fifo_empty` is high exactly when that number is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock at the 10 ns count rate |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_sel | input | 2 | Reference rate select (step per tick) |
| ref_tick | input | 1 | One-cycle pulse per reference period |
| trig_in | input | 1 | Asynchronous trigger input |
| clr_in | input | 1 | Asynchronous start-of-run clear |
| time_now | output | CNT_W (48) | Current counter value |
| rd_valid | output | 1 | A read word is available |
| rd_ready | input | 1 | Host accepts the current word |
| rd_data | output | 32 | Low or high word of the head stamp |
| rd_hi | output | 1 | High when `rd_data` carries the high word |
| fifo_empty | output | 1 | Queue holds no stamp |
| fifo_count | output | 7 | Number of stored stamps |
| overflow | output | 1 | Sticky flag for a dropped trigger |
| ovf_clr | input | 1 | Host write that clears `overflow` |

## Verification
The hardest condition to reach from the ports is the counter wrap. With 48 bits, it takes far more reference ticks than any run allows. The bench therefore builds a second copy of the block with a 10-bit counter and drives it with the same stimulus. At the largest step, that copy wraps within about a hundred cycles, and the bench checks that it keeps matching the reference model modulo 2^10. Queue overflow is reached by holding `rd_ready` low through more than 64 trigger pulses. The bench then confirms that reads leave the flag set and that only `ovf_clr` removes it.

// File: rtl/tsc_pkg.sv
`timescale 1ns/1ps
package tsc_pkg;

  localparam int WORD_W = 32;
  localparam int PAD_W  = 2 * WORD_W;

  typedef enum logic [1:0] {
    RATE_FULL  = 2'd0,
    RATE_QUART = 2'd1,
    RATE_TENTH = 2'd2,
    RATE_RSVD  = 2'd3
  } rate_sel_e;

  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_e;

  function automatic logic [3:0] tick_step(input logic [1:0] sel);
    case (rate_sel_e'(sel))
      RATE_QUART: tick_step = 4'd4;
      RATE_TENTH: tick_step = 4'd10;
      default:    tick_step = 4'd1;
    endcase
  endfunction

endpackage

// File: rtl/tsc_edge_sync.sv
`timescale 1ns/1ps
module tsc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);

  logic [STAGES:0] shr;

  always_ff @(posedge clk) begin
    if (!rst_n) shr <= '0;
    else        shr <= {shr[STAGES-1:0], din};
  end

  assign rise = shr[STAGES-1] & ~shr[STAGES];

  p_one_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/tsc_time_base.sv
`timescale 1ns/1ps
module tsc_time_base
  import tsc_pkg::*;
#(
  parameter int CNT_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [1:0]       sel,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] stamp
);

  logic [CNT_W-1:0] step_ext;

  assign step_ext = CNT_W'(tick_step(sel));

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (tick)  cnt <= cnt + step_ext;
  end

  assign stamp = clr ? '0 : cnt;

  p_clear_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));

  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !tick) |=> $stable(cnt));

  p_tie_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> (stamp == '0));

endmodule

// File: rtl/tsc_stamp_fifo.sv
`timescale 1ns/1ps
module tsc_stamp_fifo #(
  parameter int W     = 48,
  parameter int DEPTH = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               push_data,
  input  logic                       pop,
  input  logic                       ovf_clr,
  output logic [W-1:0]               head,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       ovf
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH-1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          full, do_push, do_pop, drop;

  assign full    = (count == FULL);
  assign do_push = push && !full;
  assign drop    = push && full;
  assign do_pop  = pop && (count != '0);

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       ovf <= 1'b0;
    else if (drop)    ovf <= 1'b1;
    else if (ovf_clr) ovf <= 1'b0;
  end

  assign head = mem[rd_ptr];

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL);

  p_drop_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> ovf);

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ovf_clr) |=> ovf);

  p_both_act_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && (count != '0) && !full) |=> $stable(count));

endmodule

// File: rtl/tsc_word_port.sv
`timescale 1ns/1ps
module tsc_word_port
  import tsc_pkg::*;
#(
  parameter int W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      head,
  input  logic              avail,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_hi,
  output logic              pop
);

  half_e            half;
  logic [PAD_W-1:0] padded;
  logic             xfer;

  assign padded   = PAD_W'(head);
  assign rd_valid = avail;
  assign xfer     = avail && rd_ready;
  assign pop      = xfer && (half == HALF_HI);
  assign rd_hi    = (half == HALF_HI);
  assign rd_data  = (half == HALF_HI) ? padded[PAD_W-1:WORD_W] : padded[WORD_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)    half <= HALF_LO;
    else if (xfer) half <= (half == HALF_HI) ? HALF_LO : HALF_HI;
  end

  p_hold_backpressure_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) && $stable(rd_hi)));

  p_low_then_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && !rd_hi) |=> (rd_valid && rd_hi));

endmodule

// File: rtl/tstamp_capture.sv
`timescale 1ns/1ps
module tstamp_capture
  import tsc_pkg::*;
#(
  parameter int CNT_W       = 48,
  parameter int DEPTH       = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [1:0]                 ref_sel,
  input  logic                       ref_tick,
  input  logic                       trig_in,
  input  logic                       clr_in,
  output logic [CNT_W-1:0]           time_now,
  output logic                       rd_valid,
  input  logic                       rd_ready,
  output logic [WORD_W-1:0]          rd_data,
  output logic                       rd_hi,
  output logic                       fifo_empty,
  output logic [$clog2(DEPTH+1)-1:0] fifo_count,
  output logic                       overflow,
  input  logic                       ovf_clr
);

  localparam int N_IN = 2;
  localparam int IDX_TRIG = 0;
  localparam int IDX_CLR  = 1;

  logic [N_IN-1:0] raw_in, rise;
  logic [CNT_W-1:0] stamp, head;
  logic pop;

  assign raw_in[IDX_TRIG] = trig_in;
  assign raw_in[IDX_CLR]  = clr_in;

  for (genvar g = 0; g < N_IN; g++) begin : g_sync
    tsc_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw_in[g]),
      .rise (rise[g])
    );
  end

  tsc_time_base #(.CNT_W(CNT_W)) i_time (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (ref_tick),
    .sel  (ref_sel),
    .clr  (rise[IDX_CLR]),
    .cnt  (time_now),
    .stamp(stamp)
  );

  tsc_stamp_fifo #(.W(CNT_W), .DEPTH(DEPTH)) i_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (rise[IDX_TRIG]),
    .push_data(stamp),
    .pop      (pop),
    .ovf_clr  (ovf_clr),
    .head     (head),
    .count    (fifo_count),
    .ovf      (overflow)
  );

  assign fifo_empty = (fifo_count == '0);

  tsc_word_port #(.W(CNT_W)) i_port (
    .clk     (clk),
    .rst_n   (rst_n),
    .head    (head),
    .avail   (!fifo_empty),
    .rd_ready(rd_ready),
    .rd_valid(rd_valid),
    .rd_data (rd_data),
    .rd_hi   (rd_hi),
    .pop     (pop)
  );

  p_capture_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rise[IDX_TRIG] && (fifo_count < ($clog2(DEPTH+1))'(DEPTH))) |=> !fifo_empty);

  p_tie_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rise[IDX_TRIG] && rise[IDX_CLR]) |=> (time_now == '0 && !fifo_empty));

endmodule

// File: tb/test_tstamp_capture.sv
`timescale 1ns/1ps
module test_tstamp_capture;

  localparam int CLK_PERIOD = 10;
  localparam int SMALL_W = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [1:0]  ref_sel = 0;
  logic        ref_tick = 0;
  logic        trig_in = 0;
  logic        clr_in = 0;
  logic        rd_ready = 0;
  logic        ovf_clr = 0;

  logic [47:0] time_now;
  logic        rd_valid, rd_hi, fifo_empty, overflow;
  logic [31:0] rd_data;
  logic [6:0]  fifo_count;

  logic [SMALL_W-1:0] s_time;
  logic        s_valid, s_hi, s_empty, s_ovf;
  logic [31:0] s_data;
  logic [6:0]  s_count;

  int n_checks = 0;
  int n_fail = 0;
  bit running = 0;
  int rd_mode = 0;
  int tick_per = 0;
  int tick_div = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tstamp_capture i_tstamp_capture (
    .clk(clk), .rst_n(rst_n), .ref_sel(ref_sel), .ref_tick(ref_tick),
    .trig_in(trig_in), .clr_in(clr_in), .time_now(time_now),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .rd_hi(rd_hi),
    .fifo_empty(fifo_empty), .fifo_count(fifo_count), .overflow(overflow),
    .ovf_clr(ovf_clr)
  );

  tstamp_capture #(.CNT_W(SMALL_W)) i_small (
    .clk(clk), .rst_n(rst_n), .ref_sel(ref_sel), .ref_tick(ref_tick),
    .trig_in(trig_in), .clr_in(clr_in), .time_now(s_time),
    .rd_valid(s_valid), .rd_ready(rd_ready), .rd_data(s_data), .rd_hi(s_hi),
    .fifo_empty(s_empty), .fifo_count(s_count), .overflow(s_ovf),
    .ovf_clr(ovf_clr)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  logic [47:0] m_cnt;
  logic [47:0] m_q[$];
  bit m_ovf, m_phase;
  bit t1, t2, t3, c1, c2, c3;
  bit te, ce, hs, drop;
  logic [47:0] m_stamp;

  function automatic int unsigned step_of(input logic [1:0] s);
    if (s == 2'd1) return 4;
    if (s == 2'd2) return 10;
    return 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_q.delete(); m_ovf = 0; m_phase = 0;
      t1 = 0; t2 = 0; t3 = 0; c1 = 0; c2 = 0; c3 = 0;
    end else begin
      te = t2 && !t3;
      ce = c2 && !c3;
      m_stamp = ce ? 48'd0 : m_cnt;
      hs = (m_q.size() != 0) && rd_ready;
      drop = te && (m_q.size() == 64);
      if (hs) begin
        if (m_phase) begin void'(m_q.pop_front()); m_phase = 0; end
        else m_phase = 1;
      end
      if (te && !drop) m_q.push_back(m_stamp);
      if (drop) m_ovf = 1;
      else if (ovf_clr) m_ovf = 0;
      if (ce) m_cnt = 0;
      else if (ref_tick) m_cnt = m_cnt + 48'(step_of(ref_sel));
      t3 = t2; t2 = t1; t1 = trig_in;
      c3 = c2; c2 = c1; c1 = clr_in;
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (running) begin
      logic [31:0] e_data, e_sdata;
      bit e_valid;
      e_valid = (m_q.size() != 0);
      e_data = 0; e_sdata = 0;
      if (e_valid) begin
        e_data  = m_phase ? {16'd0, m_q[0][47:32]} : m_q[0][31:0];
        e_sdata = m_phase ? 32'd0 : {22'd0, m_q[0][9:0]};
      end
      check("R2 time_now", time_now, m_cnt);
      check("R11 fifo_count", fifo_count, m_q.size());
      check("R11 fifo_empty", fifo_empty, !e_valid);
      check("R9 overflow", overflow, m_ovf);
      check("R7 rd_valid", rd_valid, e_valid);
      if (e_valid) begin
        check("R6 rd_data", rd_data, e_data);
        check("R6 rd_hi", rd_hi, m_phase);
      end
      check("R10 narrow time_now", s_time, m_cnt[SMALL_W-1:0]);
      check("R10 narrow rd_valid", s_valid, e_valid);
      if (e_valid) check("R10 narrow rd_data", s_data, e_sdata);
    end
  end

  // Host read-ready and reference-tick generators
  always @(negedge clk) begin
    if (rd_mode == 1) rd_ready = ($urandom % 2) == 1;
    else if (rd_mode == 2) rd_ready = 1;
    else if (rd_mode == 0) rd_ready = 0;
    if (tick_per > 0) begin
      tick_div++;
      ref_tick = (tick_div % tick_per) == 0;
    end
  end

  // Wrap watch on the narrow copy
  bit wrap_watch = 0;
  bit wrapped = 0;
  logic [SMALL_W-1:0] s_prev = 0;
  always @(negedge clk) begin
    if (wrap_watch) begin
      if (s_time < s_prev) wrapped = 1;
      s_prev = s_time;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_trig();
    trig_in = 1; cyc(1); trig_in = 0; cyc(1);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : stim
    logic [47:0] t0;
    cyc(3);
    rst_n = 1;
    running = 1;
    cyc(1);
    check("R1 time_now", time_now, 0);
    check("R1 fifo_empty", fifo_empty, 1);
    check("R1 fifo_count", fifo_count, 0);
    check("R1 overflow", overflow, 0);
    check("R1 rd_valid", rd_valid, 0);

    // R2: each rate select
    ref_sel = 0; tick_per = 1; cyc(50);
    ref_sel = 1; tick_per = 4; cyc(80);
    ref_sel = 2; tick_per = 10; cyc(100);
    ref_sel = 3; tick_per = 3; cyc(30);
    tick_per = 0; ref_tick = 0; cyc(3);
    t0 = time_now;
    ref_sel = 2; ref_tick = 1; cyc(1); ref_tick = 0; cyc(1);
    check("R2 single tick step 10", time_now, t0 + 48'd10);
    cyc(3);
    check("R2 hold without tick", time_now, t0 + 48'd10);

    // R3: clear edge, then held level
    clr_in = 1; cyc(1); clr_in = 0; cyc(3);
    check("R3 clear zeroes counter", time_now, 0);
    ref_sel = 0; tick_per = 1;
    clr_in = 1; cyc(20);
    check("R3 held clear acts once", time_now != 0, 1);
    clr_in = 0; cyc(2);

    // R8: random triggers under random back-pressure
    rd_mode = 1;
    for (int i = 0; i < 400; i++) begin
      trig_in = ($urandom % 2) == 1;
      clr_in = ($urandom % 64) == 0;
      cyc(1);
    end
    trig_in = 0; clr_in = 0;
    rd_mode = 2; cyc(200);
    check("R8 queue drained after mixed traffic", fifo_empty, 1);

    // R4: held trigger level gives one stamp
    rd_mode = 0; cyc(1);
    trig_in = 1; cyc(20); trig_in = 0; cyc(4);
    check("R4 held trigger single stamp", fifo_count, 1);
    rd_mode = 2; cyc(5); rd_mode = 0; cyc(1);

    // R5: trigger and clear together
    trig_in = 1; clr_in = 1; cyc(1); trig_in = 0; clr_in = 0; cyc(4);
    check("R5 one stamp stored", fifo_count, 1);
    check("R5 stamp low word zero", rd_data, 0);
    check("R5 low word first", rd_hi, 0);
    check("R5 counter restarted", time_now < 48'd20, 1);

    // R6 / R7: two-word read, pop after high word
    rd_mode = 3; rd_ready = 1; cyc(1); rd_ready = 0;
    check("R6 high word follows", rd_hi, 1);
    check("R6 no pop after low word", fifo_count, 1);
    cyc(3);
    check("R7 word held under back-pressure", rd_hi, 1);
    check("R7 valid held under back-pressure", rd_valid, 1);
    check("R6 high word of zero stamp", rd_data, 0);
    rd_ready = 1; cyc(1); rd_ready = 0;
    check("R6 pop after high word", fifo_empty, 1);

    // R9: overflow
    rd_mode = 0; cyc(1);
    for (int i = 0; i < 70; i++) pulse_trig();
    cyc(4);
    check("R9 queue full at depth", fifo_count, 64);
    check("R9 overflow set", overflow, 1);
    rd_mode = 2; cyc(10); rd_mode = 0; cyc(1);
    check("R9 reads keep overflow", overflow, 1);
    ovf_clr = 1; cyc(1); ovf_clr = 0; cyc(1);
    check("R9 host write clears overflow", overflow, 0);
    rd_mode = 2; cyc(200);

    // R10: wrap on the narrow copy
    clr_in = 1; cyc(1); clr_in = 0; cyc(4);
    ref_sel = 2; tick_per = 1;
    s_prev = s_time; wrap_watch = 1;
    cyc(300);
    wrap_watch = 0;
    check("R10 narrow counter wrapped", wrapped, 1);
    check("R10 no overflow on wrap", s_ovf, 0);

    running = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule